// File: doc/BRIEF.md
# Two-Stage Long-Delay Compare Timer

This block builds one long delay out of two short counters placed in series. A lead counter starts on a `start` pulse. A prescaler clocks it. When the count reaches `lead_cmp`, the lead counter sends a single-cycle trigger and halts. A rising edge on that trigger arms a tail counter. The tail counter runs once through its full range and then stops by itself.

The tail counter has several compare channels. Each channel has its own compare value and its own output mode. When the tail count meets a channel's value, that channel's pin is updated and its event line pulses for one cycle. Each stage has its own prescaler, so either stage can supply the coarse part of the delay and the other the fine part. For example, a divide of 65536 on the tail and no division on the lead makes each tail compare value the high half of a 32-bit delay.

Typical use: program the compare values, prescalers and modes, then pulse `start`. No further action is needed until the channel events arrive.

Top module: `chained_delay_cmp`

## Requirements
- R1: After reset, `ch_out`, `ch_evt`, `lead_trig` and `tail_wrap` are all low, and both counters are idle.
- R2: Let the edge that samples `start` high be edge 0. `lead_trig` is high for exactly one cycle, following edge `lead_cmp*(lead_div+1)`, and the lead counter then halts. A new `start` restarts the lead count from zero at any time, including after it has halted.
- R3: The tail counter starts on the edge after `lead_trig` rises. A channel with a non-zero compare value H matches on the edge `H*(tail_div+1)` after the tail start.
- R4: A trigger rising edge that arrives while the tail counter is running is ignored. The tail count is neither restarted nor changed, and channel match times keep their original values.
- R5: The tail counter stops by itself on the tick that wraps its count from all-ones to zero. `tail_wrap` pulses for one cycle following that edge, which is `2^CNT_W*(tail_div+1)` edges after the tail start. No channel matches again until the tail counter is retriggered.
- R6: Mode code 2'b01 on `ch_mode[2i+1:2i]` drives channel i's pin high on a match.
- R7: Mode code 2'b10 drives the pin low on a match.
- R8: Mode code 2'b11 inverts the pin on a match.
- R9: Mode code 2'b00 leaves the pin unchanged on a match.
- R10: Every channel match raises that channel's `ch_evt` bit for exactly one cycle, whatever the mode.
- R11: A tail compare value of zero matches on the wrap edge of the tail counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that starts (or restarts) the lead counter |
| lead_cmp | input | CNT_W | Lead compare value, counted in lead ticks |
| lead_div | input | PRE_W | Lead prescaler; one tick every lead_div+1 cycles |
| tail_div | input | PRE_W | Tail prescaler; one tick every tail_div+1 cycles |
| tail_cmp | input | N_CH*CNT_W | Tail compare values; channel i uses bits [CNT_W*i +: CNT_W] |
| ch_mode | input | 2*N_CH | Channel output modes, 2 bits per channel |
| ch_out | output | N_CH | Registered channel pins |
| ch_evt | output | N_CH | One-cycle match pulses, one per channel |
| lead_trig | output | 1 | One-cycle lead compare pulse that arms the tail |
| tail_wrap | output | 1 | One-cycle pulse when the tail counter wraps and stops |

## Verification
The assertions assume that the prescaler divides, compare values and modes stay constant while either counter is running. The one-tick spacing check and the output-mode checks depend on these inputs being steady.

The stimulus changes these inputs only before `start` and only after the tail counter has wrapped and the observation window has closed. Each window runs long enough to show that nothing fires after the wrap.

Lead compare values are kept non-zero and small, so the lead trigger arrives well before the tail wraps. In one directed run, a second `start` is issued after the tail has begun, so the retrigger rule is exercised against a running tail.

// File: rtl/ldc_pkg.sv
package ldc_pkg;

  // Channel reaction on a compare match
  typedef enum logic [1:0] {
    CH_HOLD = 2'b00,
    CH_SET  = 2'b01,
    CH_CLR  = 2'b10,
    CH_FLIP = 2'b11
  } ch_mode_e;

endpackage

// File: rtl/ldc_prescaler.sv
module ldc_prescaler #(
  parameter int PRE_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             clr,
  input  logic [PRE_W-1:0] div,
  output logic             tick
);

  logic [PRE_W-1:0] pre_q;
  logic             at_top;

  assign at_top = (pre_q >= div);
  assign tick   = en && !clr && at_top;

  always_ff @(posedge clk) begin
    if (rst || clr || !en) begin
      pre_q <= '0;
    end else if (at_top) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_q + PRE_W'(1);
    end
  end

  // R3 / R2: with a steady non-zero divide, ticks never come back to back
  a_r3_tick_spacing: assert property (@(posedge clk) disable iff (rst)
    (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/ldc_stage.sv
module ldc_stage #(
  parameter int CNT_W    = 16,
  parameter int PRE_W    = 16,
  parameter bit ONE_SHOT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             stop,
  input  logic [PRE_W-1:0] div,
  output logic             run,
  output logic             tick,
  output logic [CNT_W-1:0] cnt
);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             go_ok;
  logic             wrap_now;
  logic             self_stop;

  assign wrap_now = tick && (cnt_q == '1);

  generate
    if (ONE_SHOT) begin : g_trig
      // trigger mode: an edge only starts an idle counter
      assign go_ok     = go && !run_q;
      assign self_stop = wrap_now;
    end else begin : g_restart
      assign go_ok     = go;
      assign self_stop = 1'b0;
    end
  endgenerate

  ldc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk  (clk),
    .rst  (rst),
    .en   (run_q),
    .clr  (go_ok),
    .div  (div),
    .tick (tick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (go_ok) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else begin
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
      if (stop || self_stop) run_q <= 1'b0;
    end
  end

  assign run = run_q;
  assign cnt = cnt_q;

  // R5: an idle counter holds its value until it is started
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !go) |=> $stable(cnt_q));

  generate
    if (ONE_SHOT) begin : g_chk
      // R5: the wrap tick ends the run
      a_r5_stop_at_wrap: assert property (@(posedge clk) disable iff (rst)
        (run_q && tick && cnt_q == '1) |=> !run_q);
      // R4: a start request during a run neither restarts nor stops it
      a_r4_no_retrigger: assert property (@(posedge clk) disable iff (rst)
        (run_q && go && !(tick && cnt_q == '1)) |=>
          (run_q && cnt_q == $past(cnt_q) + CNT_W'($past(tick))));
    end
  endgenerate

endmodule

// File: rtl/ldc_channel.sv
module ldc_channel
  import ldc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  ch_mode_e         mode,
  output logic             out,
  output logic             evt
);

  logic [CNT_W-1:0] cnt_nxt;
  logic             match;
  logic             out_q;
  logic             evt_q;

  // a match is the tick that moves the count onto the compare value
  assign cnt_nxt = cnt + CNT_W'(1);
  assign match   = tick && (cnt_nxt == cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      evt_q <= match;
      if (match) begin
        case (mode)
          CH_SET:  out_q <= 1'b1;
          CH_CLR:  out_q <= 1'b0;
          CH_FLIP: out_q <= ~out_q;
          default: out_q <= out_q;
        endcase
      end
    end
  end

  assign out = out_q;
  assign evt = evt_q;

  a_r6_set_high: assert property (@(posedge clk) disable iff (rst)
    (match && mode == CH_SET) |=> out_q);
  a_r7_clr_low: assert property (@(posedge clk) disable iff (rst)
    (match && mode == CH_CLR) |=> !out_q);
  a_r8_flip: assert property (@(posedge clk) disable iff (rst)
    (match && mode == CH_FLIP) |=> (out_q != $past(out_q)));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (match && mode == CH_HOLD) |=> $stable(out_q));
  a_r10_evt_follows: assert property (@(posedge clk) disable iff (rst)
    match |=> evt_q);

endmodule

// File: rtl/chained_delay_cmp.sv
module chained_delay_cmp
  import ldc_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 16,
  parameter int N_CH  = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [CNT_W-1:0]      lead_cmp,
  input  logic [PRE_W-1:0]      lead_div,
  input  logic [PRE_W-1:0]      tail_div,
  input  logic [N_CH*CNT_W-1:0] tail_cmp,
  input  logic [2*N_CH-1:0]     ch_mode,
  output logic [N_CH-1:0]       ch_out,
  output logic [N_CH-1:0]       ch_evt,
  output logic                  lead_trig,
  output logic                  tail_wrap
);

  localparam int MW = 2;

  logic             lead_run, lead_tick;
  logic [CNT_W-1:0] lead_cnt;
  logic             lead_match;
  logic             trig_q, trig_d_q;
  logic             tail_go;
  logic             tail_run, tail_tick;
  logic [CNT_W-1:0] tail_cnt;
  logic             wrap_q;

  // lead stage: restartable, halts on its own compare match
  ldc_stage #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ONE_SHOT(1'b0)) u_lead (
    .clk  (clk),
    .rst  (rst),
    .go   (start),
    .stop (lead_match),
    .div  (lead_div),
    .run  (lead_run),
    .tick (lead_tick),
    .cnt  (lead_cnt)
  );

  assign lead_match = lead_run && lead_tick &&
                      ((lead_cnt + CNT_W'(1)) == lead_cmp);

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_q   <= 1'b0;
      trig_d_q <= 1'b0;
      wrap_q   <= 1'b0;
    end else begin
      trig_q   <= lead_match;
      trig_d_q <= trig_q;
      wrap_q   <= tail_tick && (tail_cnt == '1);
    end
  end

  // tail is armed by the rising edge of the lead trigger
  assign tail_go = trig_q && !trig_d_q;

  ldc_stage #(.CNT_W(CNT_W), .PRE_W(PRE_W), .ONE_SHOT(1'b1)) u_tail (
    .clk  (clk),
    .rst  (rst),
    .go   (tail_go),
    .stop (1'b0),
    .div  (tail_div),
    .run  (tail_run),
    .tick (tail_tick),
    .cnt  (tail_cnt)
  );

  generate
    for (genvar i = 0; i < N_CH; i++) begin : g_ch
      ldc_channel #(.CNT_W(CNT_W)) u_ch (
        .clk  (clk),
        .rst  (rst),
        .tick (tail_tick),
        .cnt  (tail_cnt),
        .cmp  (tail_cmp[CNT_W*i +: CNT_W]),
        .mode (ch_mode_e'(ch_mode[MW*i +: MW])),
        .out  (ch_out[i]),
        .evt  (ch_evt[i])
      );

      // R10: one tail run yields each count value once, so events are single cycles
      a_r10_evt_single: assert property (@(posedge clk) disable iff (rst)
        ch_evt[i] |=> !ch_evt[i]);
    end
  endgenerate

  assign lead_trig = trig_q;
  assign tail_wrap = wrap_q;

  // R3: the tail only ever begins right after a lead trigger
  a_r3_tail_from_trig: assert property (@(posedge clk) disable iff (rst)
    $rose(tail_run) |-> $past(trig_q));
  // R2: the trigger is a single-cycle pulse
  a_r2_trig_single: assert property (@(posedge clk) disable iff (rst)
    trig_q |=> !trig_q);
  // R5: a wrap pulse leaves the tail idle
  a_r5_wrap_idle: assert property (@(posedge clk) disable iff (rst)
    wrap_q |-> !tail_run);

endmodule

// File: tb/sim_chained_delay_cmp.sv
module sim_chained_delay_cmp;

  localparam int CW = 8;
  localparam int PW = 8;
  localparam int NC = 3;
  localparam int SPAN = 1 << CW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [CW-1:0] lead_cmp = '0;
  logic [PW-1:0] lead_div = '0;
  logic [PW-1:0] tail_div = '0;
  logic [NC*CW-1:0] tail_cmp = '0;
  logic [2*NC-1:0]  ch_mode = '0;
  logic [NC-1:0] ch_out, ch_evt;
  logic lead_trig, tail_wrap;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  bit exp_lvl [NC];

  always #4 clk = ~clk;

  chained_delay_cmp #(.CNT_W(CW), .PRE_W(PW), .N_CH(NC)) u0 (
    .clk(clk), .rst(rst), .start(start), .lead_cmp(lead_cmp),
    .lead_div(lead_div), .tail_div(tail_div), .tail_cmp(tail_cmp),
    .ch_mode(ch_mode), .ch_out(ch_out), .ch_evt(ch_evt),
    .lead_trig(lead_trig), .tail_wrap(tail_wrap)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit next_lvl(input int mode, input bit cur);
    case (mode)
      1: return 1'b1;
      2: return 1'b0;
      3: return ~cur;
      default: return cur;
    endcase
  endfunction

  function automatic string mode_req(input int mode);
    case (mode)
      1: return "R6";
      2: return "R7";
      3: return "R8";
      default: return "R9";
    endcase
  endfunction

  // one full lead+tail sequence; restart_at < 0 means no second start
  task automatic run_seq(input int L, input int dl, input int dt,
                         input int h0, input int h1, input int h2,
                         input int m0, input int m1, input int m2,
                         input int restart_at);
    int h[NC]; int m[NC];
    int exp_t[NC]; int seen_n[NC]; int seen_t[NC];
    int lead_t, lead_t2, wrap_t, last_t;
    int lead_n, lead_first, lead_second, wrap_n, wrap_seen;
    string treq;
    h[0] = h0; h[1] = h1; h[2] = h2;
    m[0] = m0; m[1] = m1; m[2] = m2;
    lead_t = L * (dl + 1);
    wrap_t = lead_t + 1 + SPAN * (dt + 1);
    lead_t2 = (restart_at >= 0) ? restart_at + 1 + lead_t : -1;
    last_t = wrap_t + 45 * (dt + 1) + 3;
    for (int c = 0; c < NC; c++) begin
      exp_t[c] = (h[c] == 0) ? wrap_t : lead_t + 1 + h[c] * (dt + 1);
      seen_n[c] = 0; seen_t[c] = -1;
    end
    lead_n = 0; lead_first = -1; lead_second = -1; wrap_n = 0; wrap_seen = -1;
    @(negedge clk);
    lead_cmp = CW'(L);
    lead_div = PW'(dl);
    tail_div = PW'(dt);
    tail_cmp = {CW'(h2), CW'(h1), CW'(h0)};
    ch_mode  = {2'(m2), 2'(m1), 2'(m0)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int t = 0; t <= last_t; t++) begin
      if (lead_trig) begin
        lead_n++;
        if (lead_first < 0) lead_first = t; else lead_second = t;
      end
      if (tail_wrap) begin wrap_n++; wrap_seen = t; end
      for (int c = 0; c < NC; c++)
        if (ch_evt[c]) begin seen_n[c]++; if (seen_t[c] < 0) seen_t[c] = t; end
      start = (t == restart_at);
      @(negedge clk);
    end
    start = 1'b0;
    // R2: lead trigger time and count
    chk(lead_first == lead_t, "R2 lead trigger time", lead_first, lead_t);
    chk(lead_n == ((restart_at >= 0) ? 2 : 1), "R2 lead trigger count",
        lead_n, (restart_at >= 0) ? 2 : 1);
    if (restart_at >= 0)
      chk(lead_second == lead_t2, "R2 restarted trigger time", lead_second, lead_t2);
    // R5: single wrap at the expected time
    chk(wrap_n == 1 && wrap_seen == wrap_t, "R5 tail wrap time", wrap_seen, wrap_t);
    for (int c = 0; c < NC; c++) begin
      treq = (restart_at >= 0) ? "R4 match time under retrigger" :
             (h[c] == 0) ? "R11 zero compare at wrap" : "R3 match time";
      // R10 / R5: exactly one event, none after the stop
      chk(seen_n[c] == 1, "R10 event count", seen_n[c], 1);
      chk(seen_t[c] == exp_t[c], treq, seen_t[c], exp_t[c]);
      exp_lvl[c] = next_lvl(m[c], exp_lvl[c]);
      chk(ch_out[c] == exp_lvl[c], mode_req(m[c]), int'(ch_out[c]), int'(exp_lvl[c]));
    end
  endtask

  initial begin
    void'($urandom(32'd1729));
    for (int c = 0; c < NC; c++) exp_lvl[c] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk(ch_out == '0, "R1 pins low", int'(ch_out), 0);
    chk(ch_evt == '0, "R1 events low", int'(ch_evt), 0);
    chk(lead_trig == 1'b0, "R1 trigger low", int'(lead_trig), 0);
    chk(tail_wrap == 1'b0, "R1 wrap low", int'(tail_wrap), 0);

    // directed: set, flip, hold
    run_seq(6, 0, 0, 10, 3, 40, 1, 3, 0, -1);
    // directed: clear, flip, set, prescaled stages
    run_seq(3, 2, 1, 5, 5, 1, 2, 3, 1, -1);
    // directed: zero compare on channel 2 (R11), hold on 0
    run_seq(2, 1, 2, 20, 7, 0, 0, 3, 3, -1);
    // directed: retrigger while tail runs (R4) and lead restart (R2)
    run_seq(4, 0, 1, 50, 10, 0, 3, 1, 2, 30);

    for (int k = 0; k < 10; k++) begin
      run_seq(int'($urandom_range(1, 20)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)),
              int'($urandom_range(0, 40)), int'($urandom_range(1, 40)),
              int'($urandom_range(1, 40)),
              int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 3)), -1);
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule